// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits on the write side of a word-wide flash array interface. It watches qualified bus writes and recognises multi-write command sequences. Every sequence opens with the same two key writes. A third write then picks the command. A program command takes one more write, which carries the target. An erase or protection command takes a second pair of key writes and a selector write. When a sequence completes and passes the boot-region guard, the decoder hands one registered request (kind, address, data) to an operation engine for a single clock cycle.

The decoder also keeps an identification-mode flag and a boot-protection flag. While identification mode is on, a read multiplexer returns a maker code, a device code or the protection state, chosen by the bus address. The protection flag blocks program and erase requests that would touch the boot region, unless the high-voltage override input is held.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A clock cycle counts as one write only when `chip_sel`=1, `wr_en`=1 and `out_en`=0. A cycle that misses any of these leaves the sequence state unchanged.
- R2: Command matching looks only at `bus_addr[14:0]` and `bus_wdata[7:0]`. Higher address bits and the upper data byte do not change what a key or command write means. The first key is data AA at 5555 hex and the second key is data 55 at 2AAA hex.
- R3: The keys followed by A0 at 5555 arm a program. The next write produces `req_valid`=1 in the cycle after it, with `req_kind`=1 and that write's full address and data.
- R4: The keys, then 80 at 5555, then the keys again, then a selector write produce an erase request. The selector 10 at 5555 gives `req_kind`=2 (whole array). The selector 30 at any address gives `req_kind`=3 (sector), and `req_addr` carries that address.
- R5: The keys, then 80 at 5555, the keys again, then 40 at 5555 give `req_kind`=4 and set the boot-protection flag. The flag stays set until reset.
- R6: The keys followed by 90 at 5555 set `id_mode`. The keys followed by F0 at 5555 clear it. While no sequence is in progress, a single write of F0 at any address also clears it. Entering or leaving identification mode issues no request.
- R7: With `id_mode`=1, `id_rdata` is 00DA hex for `bus_addr`=0 and 0FAE hex for `bus_addr`=1. For `bus_addr`=2 it returns the protection flag in bit 0. Any other address returns 0, and `id_mode`=0 returns 0.
- R8: With the protection flag set and `hv_override`=0, no request is issued for a program or sector erase whose address is 0 to 1FFF hex, and none for a whole-array erase. With `hv_override`=1 these requests are issued.
- R9: A write that does not match the expected step returns the decoder to idle without a request. A following target write then produces nothing.
- R10: Writes made while `engine_busy`=1 are ignored, and an armed sequence stays armed.
- R11: Synchronous active-low reset clears the sequence step, `id_mode`, the protection flag and `req_valid`.
- R12: `req_valid` is a pulse one cycle long. Its kind codes are 1 program, 2 whole-array erase, 3 sector erase and 4 protection set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write enable, active high |
| out_en | input | 1 | Output enable, active high; blocks writes |
| bus_addr | input | 17 | Word address for writes and ID reads |
| bus_wdata | input | 16 | Write data |
| engine_busy | input | 1 | Operation engine busy; writes ignored |
| hv_override | input | 1 | High-voltage override of boot protection |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | Request kind code |
| req_addr | output | 17 | Request target address |
| req_data | output | 16 | Request data |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 16 | Identification read data |

## Verification
Each command sequence is run with its exact keys. One run sets the high address bits and the upper data byte on its key writes, to show that only the compared fields matter. Sequences broken at the second key, at the opcode and at the opcode address must end idle, which separates a strict step match from a loose one. Writes that arrive while busy, with output enable high or without chip select are placed inside an armed program. These show that such writes are dropped without aborting the sequence. Program and erase targets just inside and just outside the boot region are tried with and without the override, so the guard boundary and its bypass are each pinned down.

// File: rtl/fcd_pkg.sv
// Shared types and constants for the flash command decoder.
// Assumes: the compared address field is 15 bits and the compared data field is 8 bits.
package fcd_pkg;
    localparam int CMP_A_W = 15;
    localparam int CMP_D_W = 8;

    localparam logic [CMP_A_W-1:0] ADR_KEY_A = 15'h5555;
    localparam logic [CMP_A_W-1:0] ADR_KEY_B = 15'h2AAA;

    localparam logic [CMP_D_W-1:0] KEY_A     = 8'hAA;
    localparam logic [CMP_D_W-1:0] KEY_B     = 8'h55;
    localparam logic [CMP_D_W-1:0] OP_PROG   = 8'hA0;
    localparam logic [CMP_D_W-1:0] OP_ERASE  = 8'h80;
    localparam logic [CMP_D_W-1:0] OP_ID_IN  = 8'h90;
    localparam logic [CMP_D_W-1:0] OP_ID_OUT = 8'hF0;
    localparam logic [CMP_D_W-1:0] SEL_CHIP  = 8'h10;
    localparam logic [CMP_D_W-1:0] SEL_SECT  = 8'h30;
    localparam logic [CMP_D_W-1:0] SEL_LOCK  = 8'h40;

    typedef enum logic [2:0] {
        REQ_NONE = 3'd0,
        REQ_PROG = 3'd1,
        REQ_CHIP = 3'd2,
        REQ_SECT = 3'd3,
        REQ_LOCK = 3'd4
    } req_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_EKEY1,
        ST_EKEY2,
        ST_ESEL
    } step_t;

    typedef struct packed {
        logic               key_a;
        logic               key_b;
        logic               at_a;
        logic [CMP_D_W-1:0] code;
    } wr_class_t;
endpackage

// File: rtl/fcd_match.sv
// Classifies one bus write by its compared address and data fields.
// Assumes: the caller has already sliced off the ignored upper bits.
module fcd_match
    import fcd_pkg::*;
(
    input  logic [CMP_A_W-1:0] cmp_addr,
    input  logic [CMP_D_W-1:0] cmp_data,
    output wr_class_t          cls
);
    // Decode the key writes and the opcode slot address.
    always_comb begin
        cls.at_a  = (cmp_addr == ADR_KEY_A);
        cls.key_a = cls.at_a && (cmp_data == KEY_A);
        cls.key_b = (cmp_addr == ADR_KEY_B) && (cmp_data == KEY_B);
        cls.code  = cmp_data;
    end
endmodule

// File: rtl/fcd_seq.sv
// Command step sequencer: walks the key, opcode and selector writes and
// raises a candidate request in the same cycle as the final write.
// Assumes: wr_take is already qualified by the strobes and by engine idle.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_take,
    input  logic              engine_busy,
    input  wr_class_t         cls,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cand_valid,
    output req_kind_t         cand_kind,
    output logic [ADDR_W-1:0] cand_addr,
    output logic [DATA_W-1:0] cand_data,
    output logic              id_mode
);
    step_t step_q, step_d;
    logic  id_q, id_d;

    // Next step, identification flag and candidate request for this write.
    always_comb begin
        step_d     = step_q;
        id_d       = id_q;
        cand_valid = 1'b0;
        cand_kind  = REQ_NONE;
        cand_addr  = wr_addr;
        cand_data  = wr_data;
        if (wr_take) begin
            step_d = ST_IDLE;
            unique case (step_q)
                ST_IDLE: begin
                    if (cls.key_a) begin
                        step_d = ST_KEY1;
                    end else if (id_q && cls.code == OP_ID_OUT) begin
                        id_d = 1'b0;
                    end
                end
                ST_KEY1: begin
                    if (cls.key_b) step_d = ST_KEY2;
                end
                ST_KEY2: begin
                    if (cls.at_a) begin
                        unique case (cls.code)
                            OP_PROG:   step_d = ST_PROG;
                            OP_ERASE:  step_d = ST_EKEY1;
                            OP_ID_IN:  id_d   = 1'b1;
                            OP_ID_OUT: id_d   = 1'b0;
                            default:   step_d = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    cand_valid = 1'b1;
                    cand_kind  = REQ_PROG;
                end
                ST_EKEY1: begin
                    if (cls.key_a) step_d = ST_EKEY2;
                end
                ST_EKEY2: begin
                    if (cls.key_b) step_d = ST_ESEL;
                end
                ST_ESEL: begin
                    if (cls.at_a && cls.code == SEL_CHIP) begin
                        cand_valid = 1'b1;
                        cand_kind  = REQ_CHIP;
                    end else if (cls.code == SEL_SECT) begin
                        cand_valid = 1'b1;
                        cand_kind  = REQ_SECT;
                    end else if (cls.at_a && cls.code == SEL_LOCK) begin
                        cand_valid = 1'b1;
                        cand_kind  = REQ_LOCK;
                    end
                end
                default: step_d = ST_IDLE;
            endcase
        end
    end

    // Step and identification-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            id_q   <= 1'b0;
        end else begin
            step_q <= step_d;
            id_q   <= id_d;
        end
    end

    assign id_mode = id_q;

    // R10: a busy engine freezes the sequence.
    a_r10_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> ($stable(step_q) && $stable(id_q)));

    // R6: a lone F0 write at idle leaves identification mode.
    a_r6_single_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && id_q && step_q == ST_IDLE && !cls.key_a && cls.code == OP_ID_OUT)
        |=> !id_q);

    // R9: a wrong second key drops back to idle.
    a_r9_bad_key_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && step_q == ST_KEY1 && !cls.key_b) |=> (step_q == ST_IDLE));
endmodule

// File: rtl/fcd_guard.sv
// Boot-region guard and request register: holds the protection flag and
// registers accepted candidates into a one-cycle request.
// Assumes: the boot region runs from address 0 up to BOOT_TOP inclusive.
module fcd_guard
    import fcd_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] BOOT_TOP = 17'h01FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  req_kind_t         cand_kind,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic [DATA_W-1:0] cand_data,
    input  logic              hv_override,
    output logic              req_valid,
    output req_kind_t         req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              boot_lock
);
    logic lock_q;
    logic guard_on;
    logic hits_boot;
    logic blocked;

    // Decide whether the candidate would disturb a protected boot region.
    always_comb begin
        guard_on  = lock_q && !hv_override;
        hits_boot = ((cand_kind == REQ_PROG || cand_kind == REQ_SECT) && cand_addr <= BOOT_TOP)
                    || (cand_kind == REQ_CHIP);
        blocked   = guard_on && hits_boot;
    end

    // Request strobe and payload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_kind  <= REQ_NONE;
            req_addr  <= '0;
            req_data  <= '0;
        end else begin
            req_valid <= cand_valid && !blocked;
            if (cand_valid && !blocked) begin
                req_kind <= cand_kind;
                req_addr <= cand_addr;
                req_data <= cand_data;
            end
        end
    end

    // Boot-protection flag: set by the protection command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (cand_valid && cand_kind == REQ_LOCK) begin
            lock_q <= 1'b1;
        end
    end

    assign boot_lock = lock_q;

    // R12: requests never come back to back.
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R8: no program or sector erase into the boot region while guarded.
    a_r8_boot_region: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == REQ_PROG || req_kind == REQ_SECT) && req_addr <= BOOT_TOP)
        |-> $past(!lock_q || hv_override));

    // R8: no whole-array erase while guarded.
    a_r8_no_chip_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == REQ_CHIP) |-> $past(!lock_q || hv_override));

    // R5: the protection flag does not fall without reset.
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
endmodule

// File: rtl/fcd_idmux.sv
// Identification read multiplexer.
// Assumes: the codes are returned only while identification mode is on.
module fcd_idmux #(
    parameter int                ADDR_W   = 17,
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] MAKER_ID = 16'h00DA,
    parameter logic [DATA_W-1:0] PART_ID  = 16'h0FAE
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              boot_lock,
    output logic [DATA_W-1:0] id_rdata
);
    localparam logic [ADDR_W-1:0] SLOT_MAKER = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] SLOT_PART  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SLOT_LOCK  = ADDR_W'(2);

    // Pick the identification word for the read address.
    always_comb begin
        id_rdata = '0;
        if (id_mode) begin
            if (rd_addr == SLOT_MAKER)     id_rdata = MAKER_ID;
            else if (rd_addr == SLOT_PART) id_rdata = PART_ID;
            else if (rd_addr == SLOT_LOCK) id_rdata = {{(DATA_W-1){1'b0}}, boot_lock};
        end
    end

    // R7: outside identification mode the mux is silent.
    always_comb begin
        if (!id_mode) a_r7_silent: assert (id_rdata == '0);
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the unlock-sequence command decoder: qualifies bus writes,
// classifies them, steps the command sequence, guards the boot region
// and serves identification reads.
// Assumes: one qualified write per clock cycle at most; synchronous active-low reset.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int                ADDR_W   = 17,
    parameter int                DATA_W   = 16,
    parameter logic [ADDR_W-1:0] BOOT_TOP = 17'h01FFF,
    parameter logic [DATA_W-1:0] MAKER_ID = 16'h00DA,
    parameter logic [DATA_W-1:0] PART_ID  = 16'h0FAE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic              wr_en,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              engine_busy,
    input  logic              hv_override,
    output logic              req_valid,
    output logic [2:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_rdata
);
    wr_class_t         cls;
    logic              wr_take;
    logic              cand_valid;
    req_kind_t         cand_kind;
    logic [ADDR_W-1:0] cand_addr;
    logic [DATA_W-1:0] cand_data;
    req_kind_t         kind_q;
    logic              boot_lock;

    // A write counts only with select, write enable, no output enable, engine idle.
    assign wr_take = chip_sel && wr_en && !out_en && !engine_busy;

    fcd_match u_match (
        .cmp_addr (bus_addr[CMP_A_W-1:0]),
        .cmp_data (bus_wdata[CMP_D_W-1:0]),
        .cls      (cls)
    );

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_take     (wr_take),
        .engine_busy (engine_busy),
        .cls         (cls),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .cand_valid  (cand_valid),
        .cand_kind   (cand_kind),
        .cand_addr   (cand_addr),
        .cand_data   (cand_data),
        .id_mode     (id_mode)
    );

    fcd_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_TOP(BOOT_TOP)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_valid  (cand_valid),
        .cand_kind   (cand_kind),
        .cand_addr   (cand_addr),
        .cand_data   (cand_data),
        .hv_override (hv_override),
        .req_valid   (req_valid),
        .req_kind    (kind_q),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .boot_lock   (boot_lock)
    );

    assign req_kind = kind_q;

    fcd_idmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAKER_ID(MAKER_ID), .PART_ID(PART_ID)) u_idmux (
        .id_mode   (id_mode),
        .rd_addr   (bus_addr),
        .boot_lock (boot_lock),
        .id_rdata  (id_rdata)
    );

    // R1: an unqualified cycle never yields a request in the next cycle.
    a_r1_qualified_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_sel && wr_en && !out_en) |=> !req_valid);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
// Directed bench for the command decoder: one task per scenario.
module flash_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        out_en = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        engine_busy = 1'b0;
    logic        hv_override = 1'b0;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [16:0] req_addr;
    logic [15:0] req_data;
    logic        id_mode;
    logic [15:0] id_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic        got_v;
    logic [2:0]  got_k;
    logic [16:0] got_a;
    logic [15:0] got_d;

    always #4 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .wr_en(wr_en), .out_en(out_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .engine_busy(engine_busy),
        .hv_override(hv_override), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle with chosen strobes; request outputs captured one cycle later.
    task automatic bus_wr(input logic [16:0] a, input logic [15:0] d,
                          input logic cs, input logic we, input logic oe, input logic busy);
        @(negedge clk);
        chip_sel = cs; wr_en = we; out_en = oe; engine_busy = busy;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        got_v = req_valid; got_k = req_kind; got_a = req_addr; got_d = req_data;
        chip_sel = 1'b0; wr_en = 1'b0; out_en = 1'b0; engine_busy = 1'b0;
    endtask

    task automatic wr(input logic [16:0] a, input logic [15:0] d);
        bus_wr(a, d, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic keys;
        wr(17'h05555, 16'h00AA);
        wr(17'h02AAA, 16'h0055);
    endtask

    task automatic id_read(input logic [16:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, {16'h0, id_rdata}, {16'h0, exp});
    endtask

    task automatic erase_prefix;
        keys();
        wr(17'h05555, 16'h0080);
        keys();
    endtask

    task automatic t_reset_state;
        chk("R11 req_valid after reset", {31'h0, req_valid}, 32'h0);
        chk("R11 id_mode after reset", {31'h0, id_mode}, 32'h0);
        id_read(17'h0, 16'h0000, "R7 mux silent outside id mode");
    endtask

    task automatic t_program;
        wr(17'h1D555, 16'hFFAA);
        wr(17'h0AAAA, 16'h3355);
        wr(17'h05555, 16'h00A0);
        chk("R12 no request before target", {31'h0, got_v}, 32'h0);
        wr(17'h12345, 16'hBEEF);
        chk("R3 program valid", {31'h0, got_v}, 32'h1);
        chk("R3 program kind", {29'h0, got_k}, 32'h1);
        chk("R2 program addr", {15'h0, got_a}, 32'h12345);
        chk("R3 program data", {16'h0, got_d}, 32'hBEEF);
        @(negedge clk);
        chk("R12 pulse is one cycle", {31'h0, req_valid}, 32'h0);
    endtask

    task automatic t_erase;
        erase_prefix();
        chk("R4 no request after second keys", {31'h0, got_v}, 32'h0);
        wr(17'h05555, 16'h0010);
        chk("R4 chip erase valid", {31'h0, got_v}, 32'h1);
        chk("R4 chip erase kind", {29'h0, got_k}, 32'h2);
        erase_prefix();
        wr(17'h05123, 16'h0030);
        chk("R4 sector kind", {29'h0, got_k}, 32'h3);
        chk("R4 sector addr", {15'h0, got_a}, 32'h05123);
    endtask

    task automatic t_ident;
        keys();
        wr(17'h05555, 16'h0090);
        chk("R6 entry no request", {31'h0, got_v}, 32'h0);
        chk("R6 id entered", {31'h0, id_mode}, 32'h1);
        id_read(17'h00000, 16'h00DA, "R7 maker code");
        id_read(17'h00001, 16'h0FAE, "R7 part code");
        id_read(17'h00002, 16'h0000, "R7 lock bit clear");
        id_read(17'h00003, 16'h0000, "R7 other address");
        wr(17'h00777, 16'h00F0);
        chk("R6 single write exit", {31'h0, id_mode}, 32'h0);
        id_read(17'h00000, 16'h0000, "R7 silent after exit");
        keys();
        wr(17'h05555, 16'h0090);
        keys();
        wr(17'h05555, 16'h00F0);
        chk("R6 keyed exit", {31'h0, id_mode}, 32'h0);
    endtask

    task automatic t_mismatch;
        keys();
        wr(17'h05555, 16'h0077);
        wr(17'h12345, 16'h1111);
        chk("R9 bad opcode then target", {31'h0, got_v}, 32'h0);
        wr(17'h05555, 16'h00AA);
        wr(17'h02AAA, 16'h0056);
        wr(17'h02AAA, 16'h0055);
        wr(17'h05555, 16'h00A0);
        wr(17'h04000, 16'h2222);
        chk("R9 bad second key", {31'h0, got_v}, 32'h0);
        keys();
        wr(17'h05556, 16'h00A0);
        wr(17'h04000, 16'h3333);
        chk("R9 opcode at wrong address", {31'h0, got_v}, 32'h0);
    endtask

    task automatic t_busy;
        keys();
        wr(17'h05555, 16'h00A0);
        bus_wr(17'h03000, 16'h4444, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R10 busy write ignored", {31'h0, got_v}, 32'h0);
        wr(17'h04000, 16'h5555);
        chk("R10 still armed", {31'h0, got_v}, 32'h1);
        chk("R10 target data", {16'h0, got_d}, 32'h5555);
        chk("R10 target addr", {15'h0, got_a}, 32'h04000);
    endtask

    task automatic t_qualify;
        keys();
        wr(17'h05555, 16'h00A0);
        bus_wr(17'h03000, 16'h7777, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R1 out_en blocks", {31'h0, got_v}, 32'h0);
        bus_wr(17'h03000, 16'h7777, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1 chip_sel needed", {31'h0, got_v}, 32'h0);
        bus_wr(17'h03000, 16'h7777, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 wr_en needed", {31'h0, got_v}, 32'h0);
        wr(17'h06000, 16'h6666);
        chk("R1 armed after blocked cycles", {31'h0, got_v}, 32'h1);
        chk("R1 data of real write", {16'h0, got_d}, 32'h6666);
    endtask

    task automatic t_lock;
        erase_prefix();
        wr(17'h05555, 16'h0040);
        chk("R5 lock request valid", {31'h0, got_v}, 32'h1);
        chk("R5 lock kind", {29'h0, got_k}, 32'h4);
        keys();
        wr(17'h05555, 16'h0090);
        id_read(17'h00002, 16'h0001, "R5 lock visible");
        wr(17'h00000, 16'h00F0);
        keys(); wr(17'h05555, 16'h00A0); wr(17'h00100, 16'h1234);
        chk("R8 boot program blocked", {31'h0, got_v}, 32'h0);
        keys(); wr(17'h05555, 16'h00A0); wr(17'h01FFF, 16'h1234);
        chk("R8 boot top blocked", {31'h0, got_v}, 32'h0);
        keys(); wr(17'h05555, 16'h00A0); wr(17'h02000, 16'h1234);
        chk("R8 above boot allowed", {31'h0, got_v}, 32'h1);
        erase_prefix(); wr(17'h05555, 16'h0010);
        chk("R8 chip erase blocked", {31'h0, got_v}, 32'h0);
        erase_prefix(); wr(17'h01000, 16'h0030);
        chk("R8 boot sector blocked", {31'h0, got_v}, 32'h0);
        erase_prefix(); wr(17'h1F000, 16'h0030);
        chk("R8 main sector allowed", {31'h0, got_v}, 32'h1);
        hv_override = 1'b1;
        keys(); wr(17'h05555, 16'h00A0); wr(17'h00100, 16'h4321);
        chk("R8 override program", {31'h0, got_v}, 32'h1);
        erase_prefix(); wr(17'h05555, 16'h0010);
        chk("R8 override chip erase", {29'h0, got_k}, 32'h2);
        hv_override = 1'b0;
    endtask

    task automatic t_reset_clears;
        keys();
        wr(17'h05555, 16'h0090);
        keys();
        wr(17'h05555, 16'h00A0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 id cleared", {31'h0, id_mode}, 32'h0);
        wr(17'h04000, 16'h9999);
        chk("R11 armed step cleared", {31'h0, got_v}, 32'h0);
        keys();
        wr(17'h05555, 16'h0090);
        id_read(17'h00002, 16'h0000, "R11 lock cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_erase();
        t_ident();
        t_mismatch();
        t_busy();
        t_qualify();
        t_lock();
        t_reset_clears();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule